// File: doc/BRIEF.md
# Data Address Window Mapper

This block turns a logical data address into a physical memory address. The 64 KB logical data space is split into four windows of 16 KB each. Each window has its own 16-bit map word. The map word picks one of four target spaces: unified memory, on-chip instruction memory, on-chip data memory, or a reserved space. In I/O mode the map word works differently: it holds four 4-bit pages, one for each 4 KB sub-window, and all of them point into on-chip data memory.

A request carries a logical address and a byte count. One cycle later the response returns the physical address, the byte count cut down so the access stays inside its window, and a fault flag. The map words can be written and read at fixed on-chip data addresses, and one extra address is an alias of the third word. Physical addresses carry the space in bits 31:24: 0x00 is unified memory, 0x01 is instruction memory and 0x02 is data memory. The memories themselves are outside the block.

Top module: `dwm_mapper`

## Requirements
- R1: After reset, map words 0, 1 and 2 read 0x2000, map word 3 reads 0x0000, and rsp_valid is 0.
- R2: For a request, the window index is addr / 0x4000 and the offset is addr mod 0x4000. Any request address of 0x10000 or above gives a response with rsp_fault = 1.
- R3: When map bit 15 is 0 and bits 13:12 are 00 (unified), the physical address is seg × 0x4000 + offset. The segment seg is map bits 9:0.
- R4: When map bit 15 is 0 and bits 13:12 are 01 (instruction), the physical address is 0x01000000 + seg × 0x4000 + offset.
- R5: When map bit 15 is 0 and bits 13:12 are 10 (data), the physical address is 0x02000000 + seg × 0x10000 + index × 0x4000 + offset.
- R6: When map bit 15 is 0 and bits 13:12 are 11 (reserved), the response faults. Every faulting response has rsp_phys = 0 and rsp_len = 0.
- R7: When map bit 15 is 1 (I/O mode), bits 13:12 are ignored and the response never faults for an in-range address. The selector is s = offset[13:12]. The page is map bits [4(3−s)+3 : 4(3−s)]. The physical address is 0x02000000 + page × 0x10000 + 0xC000 + offset.
- R8: The granted length rsp_len is min(req_len, 0x4000 − offset), so the access never crosses the end of its window. A length of 0 is granted as 0.
- R9: A write to 0xFF08 + 2i loads map word i (i = 0..3). A write to 0xFF04 loads map word 2. A write to any other address changes no map word.
- R10: map_rd_data returns map word i for address 0xFF08 + 2i, and map word 2 for 0xFF04, with map_rd_hit = 1. For any other address it returns 0 with map_rd_hit = 0. The read is combinational.
- R11: Each response appears one clock after its request, and rsp_valid follows req_valid by one cycle. A request made in the same cycle as a map write uses the old map word. When rsp_valid is 0, rsp_phys, rsp_len and rsp_fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_wr_en | input | 1 | Map word write strobe |
| map_wr_addr | input | 16 | On-chip data address of the write |
| map_wr_data | input | 16 | Value to write |
| map_rd_addr | input | 16 | On-chip data address to read |
| map_rd_data | output | 16 | Map word at map_rd_addr, or 0 |
| map_rd_hit | output | 1 | map_rd_addr selects a map word |
| req_valid | input | 1 | Translate request strobe |
| req_addr | input | 24 | Logical data address |
| req_len | input | 5 | Requested byte count |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_phys | output | 32 | Physical address |
| rsp_len | output | 5 | Granted byte count |
| rsp_fault | output | 1 | Address out of range or reserved target |

## Verification
The map words are the only state in the block. A corrupted map word shows up two ways: on the read port in the same cycle it is addressed, and in rsp_phys one clock after any request that lands in its window. The bench reads back a map word every cycle and compares every response against a behavioural model. A bad register therefore shows up within one to two clocks of the first access that touches it. A wrong index or offset split shows up as a wrong rsp_len near window edges, or as an address in the wrong page within I/O sub-windows. Both are checked at the boundaries 0x3FFx and 0xFFFx.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

  localparam int MAP_W     = 16;
  localparam int MODE_BIT  = 15;
  localparam int SPACE_LSB = 12;
  localparam int SEG_W     = 10;
  localparam int PAGE_W    = 4;
  localparam int PAGES     = MAP_W / PAGE_W;

  typedef logic [MAP_W-1:0] map_word_t;

  typedef enum logic [1:0] {
    SPC_UNIFIED = 2'b00,
    SPC_INSN    = 2'b01,
    SPC_DATA    = 2'b10,
    SPC_RSVD    = 2'b11
  } space_e;

  localparam logic [31:0] BASE_UNIFIED = 32'h0000_0000;
  localparam logic [31:0] BASE_INSN    = 32'h0100_0000;
  localparam logic [31:0] BASE_DATA    = 32'h0200_0000;

  function automatic space_e map_space(input map_word_t m);
    return space_e'(m[SPACE_LSB+1:SPACE_LSB]);
  endfunction

  function automatic logic [SEG_W-1:0] map_seg(input map_word_t m);
    return m[SEG_W-1:0];
  endfunction

  function automatic logic map_io(input map_word_t m);
    return m[MODE_BIT];
  endfunction

  // Selector 0 takes the top nibble, selector 3 the bottom one.
  function automatic logic [PAGE_W-1:0] io_page(input map_word_t m, input logic [1:0] sel);
    map_word_t shifted;
    shifted = m >> (PAGE_W * (PAGES - 1 - int'(sel)));
    return shifted[PAGE_W-1:0];
  endfunction

endpackage

// File: rtl/dwm_map_regs.sv
module dwm_map_regs
  import dwm_pkg::*;
#(
  parameter int                  N_WIN      = 4,
  parameter int                  DADDR_W    = 16,
  parameter logic [DADDR_W-1:0]  MAP_BASE   = 16'hFF08,
  parameter logic [DADDR_W-1:0]  ALIAS_ADDR = 16'hFF04,
  parameter int                  ALIAS_IDX  = 2,
  parameter map_word_t           RST_LIVE   = 16'h2000,
  parameter map_word_t           RST_LAST   = 16'h0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DADDR_W-1:0]           wr_addr,
  input  map_word_t                    wr_data,
  input  logic [DADDR_W-1:0]           rd_addr,
  output map_word_t                    rd_data,
  output logic                         rd_hit,
  output logic [N_WIN-1:0][MAP_W-1:0]  map_q,
  output logic [N_WIN-1:0]             wr_hit
);

  logic [N_WIN-1:0] rd_sel;

  for (genvar i = 0; i < N_WIN; i++) begin : g_word
    localparam logic [DADDR_W-1:0] SLOT     = MAP_BASE + DADDR_W'(2 * i);
    localparam bit                 IS_ALIAS = (i == ALIAS_IDX);
    localparam map_word_t          RST_VAL  = (i == N_WIN - 1) ? RST_LAST : RST_LIVE;

    assign wr_hit[i] = wr_en && ((wr_addr == SLOT) || (IS_ALIAS && (wr_addr == ALIAS_ADDR)));
    assign rd_sel[i] = (rd_addr == SLOT) || (IS_ALIAS && (rd_addr == ALIAS_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q[i] <= RST_VAL;
      else if (wr_hit[i]) map_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    for (int k = 0; k < N_WIN; k++) begin
      if (rd_sel[k]) begin
        rd_data = map_q[k];
        rd_hit  = 1'b1;
      end
    end
  end

  // R9
  alias_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ALIAS_ADDR) |=> (map_q[ALIAS_IDX] == $past(wr_data)));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit == '0) |=> $stable(map_q));

  // R10
  read_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ALIAS_ADDR) |-> (rd_hit && rd_data == map_q[ALIAS_IDX]));

endmodule

// File: rtl/dwm_xlate.sv
module dwm_xlate
  import dwm_pkg::*;
#(
  parameter int          N_WIN      = 4,
  parameter int          WIN_W      = 14,
  parameter int          LADDR_W    = 24,
  parameter int          LEN_W      = 5,
  parameter int          PHYS_W     = 32,
  parameter int          PAGE_SHIFT = 16,
  parameter logic [31:0] IO_HOLE    = 32'h0000_C000
) (
  input  logic [N_WIN-1:0][MAP_W-1:0] map_q,
  input  logic [LADDR_W-1:0]          addr,
  input  logic [LEN_W-1:0]            len,
  output logic [PHYS_W-1:0]           phys,
  output logic [LEN_W-1:0]            grant,
  output logic                        fault,
  output logic                        ev_range,
  output logic                        ev_rsvd,
  output logic                        ev_io
);

  localparam int IDX_W   = (N_WIN > 1) ? $clog2(N_WIN) : 1;
  localparam int LOG_W   = IDX_W + WIN_W;
  localparam int SUB_MSB = WIN_W - 1;

  logic [IDX_W-1:0] idx;
  logic [WIN_W-1:0] off;
  logic [1:0]       sel;
  map_word_t        mw;

  assign idx = addr[LOG_W-1:WIN_W];
  assign off = addr[WIN_W-1:0];
  assign sel = off[SUB_MSB -: 2];

  if (LADDR_W > LOG_W) begin : g_range
    assign ev_range = |addr[LADDR_W-1:LOG_W];
  end else begin : g_norange
    assign ev_range = 1'b0;
  end

  function automatic logic [PHYS_W-1:0] seg_addr(input logic [31:0] base,
                                                 input logic [SEG_W-1:0] seg,
                                                 input logic [WIN_W-1:0] o);
    return PHYS_W'(base) + (PHYS_W'(seg) << WIN_W) + PHYS_W'(o);
  endfunction

  function automatic logic [PHYS_W-1:0] data_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [IDX_W-1:0] w,
                                                  input logic [WIN_W-1:0] o);
    return PHYS_W'(BASE_DATA) + (PHYS_W'(seg) << PAGE_SHIFT)
         + (PHYS_W'(w) << WIN_W) + PHYS_W'(o);
  endfunction

  function automatic logic [PHYS_W-1:0] io_addr(input logic [PAGE_W-1:0] page,
                                                input logic [WIN_W-1:0] o);
    return PHYS_W'(BASE_DATA) + (PHYS_W'(page) << PAGE_SHIFT)
         + PHYS_W'(IO_HOLE) + PHYS_W'(o);
  endfunction

  function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] l,
                                                input logic [WIN_W-1:0] o);
    logic [31:0] remain;
    remain = (32'd1 << WIN_W) - 32'(o);
    if (32'(l) > remain) return remain[LEN_W-1:0];
    return l;
  endfunction

  always_comb begin
    mw      = map_q[idx];
    ev_io   = map_io(mw);
    ev_rsvd = !ev_io && (map_space(mw) == SPC_RSVD);
    fault   = ev_range || ev_rsvd;
    phys    = '0;
    grant   = '0;
    if (!fault) begin
      grant = clip_len(len, off);
      if (ev_io) begin
        phys = io_addr(io_page(mw, sel), off);
      end else begin
        unique case (map_space(mw))
          SPC_UNIFIED: phys = seg_addr(BASE_UNIFIED, map_seg(mw), off);
          SPC_INSN:    phys = seg_addr(BASE_INSN, map_seg(mw), off);
          SPC_DATA:    phys = data_addr(map_seg(mw), idx, off);
          default:     phys = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dwm_mapper.sv
module dwm_mapper
  import dwm_pkg::*;
#(
  parameter int N_WIN   = 4,
  parameter int WIN_W   = 14,
  parameter int LADDR_W = 24,
  parameter int LEN_W   = 5,
  parameter int PHYS_W  = 32,
  parameter int DADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_wr_en,
  input  logic [DADDR_W-1:0] map_wr_addr,
  input  logic [15:0]        map_wr_data,
  input  logic [DADDR_W-1:0] map_rd_addr,
  output logic [15:0]        map_rd_data,
  output logic               map_rd_hit,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               rsp_valid,
  output logic [PHYS_W-1:0]  rsp_phys,
  output logic [LEN_W-1:0]   rsp_len,
  output logic               rsp_fault
);

  localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;
  localparam longint LOG_LIMIT = longint'(N_WIN) << WIN_W;

  logic [N_WIN-1:0][MAP_W-1:0] map_q;
  logic [N_WIN-1:0]            wr_hit;
  logic [PHYS_W-1:0]           x_phys;
  logic [LEN_W-1:0]            x_grant;
  logic                        x_fault;
  logic                        ev_range, ev_rsvd, ev_io;

  dwm_map_regs #(
    .N_WIN   (N_WIN),
    .DADDR_W (DADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr_en),
    .wr_addr (map_wr_addr),
    .wr_data (map_wr_data),
    .rd_addr (map_rd_addr),
    .rd_data (map_rd_data),
    .rd_hit  (map_rd_hit),
    .map_q   (map_q),
    .wr_hit  (wr_hit)
  );

  dwm_xlate #(
    .N_WIN   (N_WIN),
    .WIN_W   (WIN_W),
    .LADDR_W (LADDR_W),
    .LEN_W   (LEN_W),
    .PHYS_W  (PHYS_W)
  ) u_xlate (
    .map_q    (map_q),
    .addr     (req_addr),
    .len      (req_len),
    .phys     (x_phys),
    .grant    (x_grant),
    .fault    (x_fault),
    .ev_range (ev_range),
    .ev_rsvd  (ev_rsvd),
    .ev_io    (ev_io)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_phys  <= '0;
      rsp_len   <= '0;
      rsp_fault <= 1'b0;
    end else if (req_valid) begin
      rsp_valid <= 1'b1;
      rsp_phys  <= x_phys;
      rsp_len   <= x_grant;
      rsp_fault <= x_fault;
    end else begin
      rsp_valid <= 1'b0;
      rsp_phys  <= '0;
      rsp_len   <= '0;
      rsp_fault <= 1'b0;
    end
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_phys == '0 && rsp_len == '0 && !rsp_fault));

  // R2
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && longint'(req_addr) >= LOG_LIMIT) |=> rsp_fault);

  // R8
  len_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_len <= $past(req_len)));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_phys == '0 && rsp_len == '0));

  // R7
  io_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_io && !ev_range) |=> !rsp_fault);

  // R6
  rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_rsvd) |=> rsp_fault);

endmodule

// File: tb/tb_dwm_mapper.sv
`timescale 1ns/1ps
module tb_dwm_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr_en = 1'b0;
  logic [15:0] map_wr_addr = '0;
  logic [15:0] map_wr_data = '0;
  logic [15:0] map_rd_addr = '0;
  logic [15:0] map_rd_data;
  logic        map_rd_hit;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic        rsp_valid;
  logic [31:0] rsp_phys;
  logic [4:0]  rsp_len;
  logic        rsp_fault;

  always #2 clk = ~clk;

  dwm_mapper dut (
    .clk(clk), .rst_n(rst_n),
    .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
    .map_rd_addr(map_rd_addr), .map_rd_data(map_rd_data), .map_rd_hit(map_rd_hit),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_len(rsp_len), .rsp_fault(rsp_fault)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int mregs [4];

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  function automatic int slot_of(input int a);
    if (a == 'hFF04) return 2;
    if (a >= 'hFF08 && a <= 'hFF0E && (a % 2) == 0) return (a - 'hFF08) / 2;
    return -1;
  endfunction

  // Reference translation written straight from the requirements.
  function automatic void model(input longint a, input int ln,
                                output bit f, output longint p, output int g);
    int w, o, m, s, pg;
    f = 0; p = 0; g = 0;
    if (a >= 65536) begin f = 1; return; end
    w = int'(a) / 16384;
    o = int'(a) % 16384;
    m = mregs[w];
    if (((m / 32768) % 2) == 1) begin
      s  = (o / 4096) % 4;
      pg = (m >> (4 * (3 - s))) % 16;
      p  = 64'h0200_0000 + pg * 65536 + 'hC000 + o;
    end else begin
      case ((m / 4096) % 4)
        0: p = (m % 1024) * 16384 + o;
        1: p = 64'h0100_0000 + (m % 1024) * 16384 + o;
        2: p = 64'h0200_0000 + longint'(m % 1024) * 65536 + w * 16384 + o;
        default: begin f = 1; return; end
      endcase
    end
    g = (ln > 16384 - o) ? 16384 - o : ln;
    p = p % 64'h1_0000_0000;
  endfunction

  // Called at a negedge: drives, checks the read port, crosses one edge, checks the response.
  task automatic step(input bit we, input int wa, input int wd,
                      input bit rv, input longint ra, input int rl,
                      input int rda, input string tag);
    bit ef; longint ep; int eg; int rs; int ws;
    int erd; bit ehit;
    map_wr_en = we; map_wr_addr = wa[15:0]; map_wr_data = wd[15:0];
    req_valid = rv; req_addr = ra[23:0]; req_len = rl[4:0];
    map_rd_addr = rda[15:0];
    #1;
    rs = slot_of(rda);
    ehit = (rs >= 0);
    erd  = ehit ? mregs[rs] : 0;
    vectors++;
    if (map_rd_hit !== ehit || int'(map_rd_data) != erd) begin
      miscompares++;
      $display("FAIL R10 (%s) read 0x%04h: got hit=%0b data=0x%04h exp hit=%0b data=0x%04h",
               tag, rda, map_rd_hit, map_rd_data, ehit, erd);
    end
    @(posedge clk);
    if (rv) model(ra, rl, ef, ep, eg);
    else begin ef = 0; ep = 0; eg = 0; end
    ws = slot_of(wa);
    if (we && ws >= 0) mregs[ws] = wd % 65536;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== rv || rsp_fault !== ef || longint'(rsp_phys) != ep || int'(rsp_len) != eg) begin
      miscompares++;
      $display("FAIL %s addr 0x%06h len %0d: got v=%0b f=%0b phys=0x%08h len=%0d exp v=%0b f=%0b phys=0x%08h len=%0d",
               tag, ra, rl, rsp_valid, rsp_fault, rsp_phys, rsp_len, rv, ef, ep[31:0], eg);
    end
  endtask

  task automatic xl(input longint ra, input int rl, input string tag);
    step(0, 0, 0, 1, ra, rl, 'hFF08, tag);
  endtask

  task automatic wr(input int wa, input int wd, input string tag);
    step(1, wa, wd, 0, 0, 0, wa, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no finish, exp finish within limit");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset values from the requirement
    mregs[0] = 'h2000; mregs[1] = 'h2000; mregs[2] = 'h2000; mregs[3] = 'h0000;
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 rsp_valid in reset: got %0b exp 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 'hFF08, "R1");
    step(0, 0, 0, 0, 0, 0, 'hFF0A, "R1");
    step(0, 0, 0, 0, 0, 0, 'hFF0C, "R1");
    step(0, 0, 0, 0, 0, 0, 'hFF0E, "R1");
    step(0, 0, 0, 0, 0, 0, 'hFF04, "R10");
    step(0, 0, 0, 0, 0, 0, 'hFF06, "R10");

    // Reset map: data windows 0..2, unified window 3
    xl('h0123, 4, "R5");
    xl('h4100, 2, "R5");
    xl('h8000, 1, "R5");
    xl('hC010, 8, "R3");

    wr('hFF08, 'h0005, "R9");
    xl('h0010, 4, "R3");
    wr('hFF0A, 'h1003, "R9");
    xl('h4020, 4, "R4");
    wr('hFF04, 'h2011, "R9");
    step(0, 0, 0, 1, 'h8004, 2, 'hFF0C, "R5");
    step(0, 0, 0, 0, 0, 0, 'hFF04, "R10");

    wr('hFF0E, 'h3000, "R9");
    xl('hC000, 4, "R6");
    xl('hFFFF, 31, "R6");

    // R7: I/O pages 9, A, B, C per 4 KB sub-window
    wr('hFF0E, 'h9ABC, "R9");
    xl('hC000, 4, "R7");
    xl('hD234, 4, "R7");
    xl('hE008, 4, "R7");
    xl('hFFF0, 31, "R7");
    wr('hFF0E, 'hB000, "R9");
    xl('hC100, 3, "R7");
    xl('hF100, 3, "R7");

    // R2: out of range
    xl('h010000, 4, "R2");
    xl('hFFFFFF, 4, "R2");
    xl('h00FFFF, 1, "R2");

    // R8: window-edge clipping
    xl('h3FFE, 8, "R8");
    xl('h3FF0, 16, "R8");
    xl('h3FFF, 31, "R8");
    xl('h7FFC, 31, "R8");
    xl('h0000, 0, "R8");

    // R9: stray writes leave every word unchanged
    wr('hFF06, 'h1234, "R9");
    wr('hFF10, 'h1234, "R9");
    wr('hFF09, 'h1234, "R9");
    wr('h0008, 'h1234, "R9");
    step(0, 0, 0, 1, 'h0040, 4, 'hFF08, "R9");
    step(0, 0, 0, 1, 'h4040, 4, 'hFF0A, "R9");
    step(0, 0, 0, 1, 'h8040, 4, 'hFF0C, "R9");
    step(0, 0, 0, 1, 'hC040, 4, 'hFF0E, "R9");

    // R11: same-cycle write uses the old word, next cycle the new one
    step(1, 'hFF08, 'h1001, 1, 'h0010, 4, 'hFF08, "R11");
    xl('h0010, 4, "R11");
    step(0, 0, 0, 0, 'h0010, 4, 'hFF08, "R11");
    step(0, 0, 0, 0, 0, 0, 'hFF08, "R11");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      int pick; int wa; int ra; int rl;
      pick = int'($urandom_range(0, 7));
      case (pick)
        0: wa = 'hFF04; 1: wa = 'hFF06; 2: wa = 'hFF10; 3: wa = int'($urandom_range(0, 65535));
        default: wa = 'hFF08 + 2 * int'($urandom_range(0, 3));
      endcase
      case (int'($urandom_range(0, 5)))
        0: ra = 16384 * int'($urandom_range(0, 3)) + 16384 - int'($urandom_range(1, 20));
        1: ra = 65536 + int'($urandom_range(0, 100000));
        default: ra = int'($urandom_range(0, 65535));
      endcase
      rl = int'($urandom_range(0, 31));
      step(bit'($urandom_range(0, 1)), wa, int'($urandom_range(0, 65535)),
           bit'($urandom_range(0, 3) != 0), ra, rl,
           'hFF04 + 2 * int'($urandom_range(0, 6)), "R3");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule